// File: doc/BRIEF.md
# Tiled Unsigned Multiplier Built from Incomplete 3x2 Tiles

This block multiplies two unsigned integers, A and B, and returns the exact product P. It does not form every single-bit partial product on its own. A is cut into 3-bit slices and B into 2-bit slices. Each slice pair feeds a small tile that adds five of its six bit-products, so each tile result fits in 4 bits.

The bit-product a tile leaves out is the top bit of its A slice ANDed with the top bit of its B slice, at weight 8 inside the tile. That bit-product is formed as a separate one-bit covering term. Every tile result and every covering term is shifted to its place in the product and summed.

Operand widths that are not multiples of the slice sizes are padded with zeros. An optional output register gives one cycle of latency.

Top module: `tmul_top`

## Requirements
- R1: For every pair of unsigned operands, P equals A times B exactly.
- R2: P is A_W plus B_W bits wide.
- R3: A tile takes a 3-bit slice x and a 2-bit slice y and returns the 4-bit value x*y minus 8*(x[2] AND y[1]). That value never exceeds 13.
- R4: When A_W is not a multiple of 3, or B_W is not a multiple of 2, the operands are zero-extended to the next multiple. The extra high product bits are dropped, and the result stays exact.
- R5: The bit-product dropped by tile (i,j) is added back as a single AND term at weight 3i+2j+3. Operands that set the top bit of every slice therefore still give an exact product.
- R6: With REG_OUT=1, P changes only on a rising clock edge. After that edge, P holds the product of the A and B values that were present before the edge.
- R7: With REG_OUT=1, a synchronous active-high rst clears P to 0 on the next rising edge, whatever the operands are.
- R8: With REG_OUT=0, P follows A and B with no clock edge needed, and rst has no effect on P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | A_W | Unsigned operand A |
| b | input | B_W | Unsigned operand B |
| p | output | A_W+B_W | Unsigned product |

## Verification
The bench covers the 6x4 configuration exhaustively and tests every tile input pattern on its own. Tile-level testing exposes a tile that keeps its weight-8 bit-product, drops the wrong one, or exceeds 13. Operands with every slice top bit set (such as 63 and 15) are included because a misplaced or missing covering term shifts those products by a power of two. A second instance with 8x5 operands exercises zero-extension and exposes a wrong bound on the dropped high bits. Register checks look just before and just after each edge, and a reset with non-zero operands is applied mid-run; these checks expose a register that is transparent, adds an extra cycle of latency, or ignores reset.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
  localparam int TILE_AW = 3;
  localparam int TILE_BW = 2;
  localparam int TILE_QW = 4;
  localparam int TILE_MAX = 13;

  function automatic int round_up(input int w, input int step);
    return ((w + step - 1) / step) * step;
  endfunction
endpackage

// File: rtl/tmul_tile.sv
module tmul_tile
  import tmul_pkg::*;
(
  input  logic [TILE_AW-1:0] x,
  input  logic [TILE_BW-1:0] y,
  output logic [TILE_QW-1:0] q
);
  logic [TILE_QW-1:0] w1, w2, w4;

  always_comb begin
    w1 = TILE_QW'(x[0] & y[0]);
    w2 = TILE_QW'(x[1] & y[0]) + TILE_QW'(x[0] & y[1]);
    w4 = TILE_QW'(x[2] & y[0]) + TILE_QW'(x[1] & y[1]);
    q  = w1 + (w2 << 1) + (w4 << 2);
  end

  always_comb begin
    assert_tile_bound_R3: assert (q <= TILE_QW'(TILE_MAX))
      else $error("tile result above 13");
  end
endmodule

// File: rtl/tmul_array.sv
module tmul_array
  import tmul_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 4
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  localparam int AP = round_up(A_W, TILE_AW);
  localparam int BP = round_up(B_W, TILE_BW);
  localparam int NI = AP / TILE_AW;
  localparam int NJ = BP / TILE_BW;
  localparam int PW = AP + BP;
  localparam int OW = A_W + B_W;

  logic [AP-1:0] ap;
  logic [BP-1:0] bp;
  logic [TILE_QW-1:0] tq [NI][NJ];
  logic               cv [NI][NJ];
  logic [PW-1:0]      acc;

  assign ap = AP'(a);
  assign bp = BP'(b);

  for (genvar i = 0; i < NI; i++) begin : g_row
    for (genvar j = 0; j < NJ; j++) begin : g_col
      tmul_tile u_tile (
        .x(ap[TILE_AW*i +: TILE_AW]),
        .y(bp[TILE_BW*j +: TILE_BW]),
        .q(tq[i][j])
      );
      // covering term for the dropped top bit-product of this tile
      assign cv[i][j] = ap[TILE_AW*i + TILE_AW-1] & bp[TILE_BW*j + TILE_BW-1];
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NI; i++) begin
      for (int j = 0; j < NJ; j++) begin
        acc = acc + (PW'(tq[i][j]) << (TILE_AW*i + TILE_BW*j))
                  + (PW'(cv[i][j]) << (TILE_AW*i + TILE_BW*j + 3));
      end
    end
  end

  assign p = acc[OW-1:0];

  always_comb begin
    assert_exact_R1: assert (acc == PW'(PW'(ap) * PW'(bp)))
      else $error("tile sum differs from product");
    assert_pad_zero_R4: assert ((acc >> OW) == '0)
      else $error("padding produced high product bits");
  end
endmodule

// File: rtl/tmul_top.sv
module tmul_top
  import tmul_pkg::*;
#(
  parameter int A_W     = 6,
  parameter int B_W     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  localparam int OW = A_W + B_W;

  logic [OW-1:0] prod;

  tmul_array #(.A_W(A_W), .B_W(B_W)) u_array (
    .a(a),
    .b(b),
    .p(prod)
  );

  if (REG_OUT) begin : g_reg
    logic [OW-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else     p_q <= prod;
    end
    assign p = p_q;

    assert_reset_R7: assert property (@(posedge clk) rst |=> (p == '0))
      else $error("output not cleared by reset");
    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (p == OW'(OW'($past(a)) * OW'($past(b)))))
      else $error("registered product wrong");
  end else begin : g_comb
    assign p = prod;
  end
endmodule

// File: tb/test_tmul_top.sv
`timescale 1ns/1ps
module test_tmul_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] a = '0;
  logic [3:0] b = '0;
  logic [9:0] p;
  logic [7:0] wa = '0;
  logic [4:0] wb = '0;
  logic [12:0] wp;
  logic [2:0] tx = '0;
  logic [1:0] ty = '0;
  logic [3:0] tq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmul_top #(.A_W(6), .B_W(4), .REG_OUT(1'b1)) i_tmul_top (
    .clk(clk), .rst(rst), .a(a), .b(b), .p(p));

  tmul_top #(.A_W(8), .B_W(5), .REG_OUT(1'b0)) i_tmul_top_wide (
    .clk(clk), .rst(rst), .a(wa), .b(wb), .p(wp));

  tmul_tile i_tile (.x(tx), .y(ty), .q(tq));

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    longint expv;
    longint prev;
    // R3: every tile input pattern
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 4; y++) begin
        tx = 3'(x); ty = 2'(y);
        #1;
        expv = x * y - (((x >> 2) & (y >> 1)) * 8);
        chk("R3 tile", tq, expv);
        if (tq > 13) chk("R3 tile max", tq, 13);
      end
    end
    // R2: output width
    chk("R2 width", $bits(p), 10);
    chk("R2 width wide", $bits(wp), 13);

    // R7: reset state
    a = 6'd63; b = 4'd15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset state", p, 0);

    // R8: combinational instance ignores reset and needs no edge
    wa = 8'd200; wb = 5'd31;
    #1;
    chk("R8 comb under reset", wp, 200 * 31);

    rst = 1'b0;
    // R1/R6/R5: exhaustive, registered
    prev = 0;
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 16; y++) begin
        a = 6'(x); b = 4'(y);
        #1;
        chk("R6 hold before edge", p, prev);
        @(negedge clk);
        chk((x == 63 && y == 15) ? "R5 cover all tops" : "R1 exact", p, x * y);
        prev = x * y;
      end
    end

    // R7: mid-run reset with non-zero operands
    a = 6'd45; b = 4'd11;
    @(negedge clk);
    chk("R1 before reset", p, 45 * 11);
    rst = 1'b1;
    @(negedge clk);
    chk("R7 mid-run reset", p, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 after reset", p, 45 * 11);

    // R4: padded widths, random plus corners
    wa = 8'hFF; wb = 5'h1F; #1;
    chk("R4 max corner", wp, 255 * 31);
    wa = 8'hC0; wb = 5'h10; #1;
    chk("R4 pad corner", wp, 192 * 16);
    for (int k = 0; k < 3000; k++) begin
      wa = 8'($urandom); wb = 5'($urandom);
      #1;
      chk("R4 random", wp, longint'(wa) * longint'(wb));
    end
    finish_run();
  end
endmodule